// File: doc/BRIEF.md
# Strobed Nibble Register Loader

This block is a parallel programming port for a bank of sixteen 4-bit control slots. A host drives a 4-bit bus and one strobe line. Pulling the strobe low latches the slot address from the bus. Releasing it high latches the data for that slot from the same bus. Both inputs idle high when nothing drives them. The strobe and bus are asynchronous to the block clock, so they pass through a synchronizer chain before edge detection.

The programming slots are not cleared at power-on, but the latched output image is. It starts with the output clock source set to the reference (code 0 in slot 8) and the load divider set to divide-by-4 (code 2 in slot 9). All other slots start at zero. The output image keeps these defaults until 32 writes have completed. The write that makes 32 opens the output latch, so every programmed value appears at once. After that, each write reaches the outputs directly.

Slots 13 and 14 hold no storage and act as dummy targets for the unlock sequence. Slot 10 is reserved but keeps what is written to it.

Top module: `snl_loader`

## Requirements
- R1: A falling edge on `strobe_i` takes the slot address from `bus_i`. Later changes on the bus before the rising edge do not alter that address.
- R2: The next rising edge on `strobe_i` takes the data nibble from `bus_i` and writes it to the captured slot. Each such write counts toward unlock.
- R3: After reset, `ctrl_o` holds the default image for the first 31 writes. Nibble n is `ctrl_o[4n+3:4n]`. The default image is all zero except nibble 9 = 2. On the 32nd write, every stored slot shows its latest programmed value.
- R4: Once unlocked, a write to a stored slot appears in its nibble of `ctrl_o` three clock edges after the strobe rises at the pin.
- R5: Writes to slots 13 and 14 store nothing and leave `ctrl_o` unchanged, but they still count toward unlock.
- R6: Slot 10 stores and presents its written value like the other stored slots.
- R7: A rising strobe edge with no falling edge seen since reset, or since the last write, is ignored. It neither writes a slot nor counts toward unlock.
- R8: The write count saturates at 32, so the block stays unlocked. Only reset clears the count, which returns the outputs to the default image and requires 32 fresh writes.
- R9: While `rst_n` is low, `ctrl_o` equals the default image: slot 8 = 0 (reference source), slot 9 = 2 (divide-by-4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the programming inputs |
| rst_n | input | 1 | Active-low power-on reset |
| strobe_i | input | 1 | Programming strobe; falling edge = address phase, rising edge = data phase |
| bus_i | input | 4 | Shared address/data nibble bus |
| ctrl_o | output | 64 | Latched control image, nibble n = slot n |

## Verification
The assertions assume that `bus_i` is steady for at least three clock cycles around each strobe edge. They also assume that each strobe level lasts longer than the synchronizer depth, so every edge is seen exactly once and with the intended nibble. The stimulus follows this rule: it changes the bus and the strobe only on falling clock edges, holds each for three or four cycles, and never moves both in the same cycle. Within that timing envelope, slot addresses and data values are drawn at random, alongside directed runs that aim at:
- the orphan rising edge,
- the exact 31st and 32nd writes,
- the dummy slots,
- a second reset.

// File: rtl/snl_pkg.sv
package snl_pkg;

    // Phase of the two-edge write handshake.
    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_ADDR = 1'b1
    } arm_e;

endpackage

// File: rtl/snl_sync.sv
module snl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    // No reset: the chain simply follows the pins, also during reset.
    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/snl_strobe_decoder.sv
module snl_strobe_decoder
    import snl_pkg::*;
#(
    parameter int BUS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_s,
    input  logic [BUS_W-1:0] bus_s,
    output logic             wr_en,
    output logic [BUS_W-1:0] wr_addr,
    output logic [BUS_W-1:0] wr_data,
    output logic             stb_rise,
    output logic             armed
);

    typedef struct packed {
        arm_e             phase;
        logic [BUS_W-1:0] addr;
    } dec_t;

    dec_t st_d, st_q;
    logic prev_d, prev_q;
    logic stb_fall;

    always_comb begin
        prev_d   = stb_s;
        stb_fall = prev_q & ~stb_s;
        stb_rise = ~prev_q & stb_s;
        st_d     = st_q;
        if (stb_fall) begin
            st_d.phase = ARM_ADDR;
            st_d.addr  = bus_s;
        end else if (stb_rise) begin
            st_d.phase = ARM_IDLE;
        end
    end

    // Previous strobe level tracks the pin through reset so that a strobe
    // held low across reset release yields an orphan rising edge.
    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: ARM_IDLE, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign armed   = (st_q.phase == ARM_ADDR);
    assign wr_en   = stb_rise & armed;
    assign wr_addr = st_q.addr;
    assign wr_data = bus_s;

endmodule

// File: rtl/snl_unlock_counter.sv
module snl_unlock_counter #(
    parameter int LIMIT = 32,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    output logic [CNT_W-1:0] count_q,
    output logic             open_d,
    output logic             open_q
);

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_en && (cnt_q.count != LIMIT_C)) begin
            cnt_d.count = cnt_q.count + 1'b1;
        end
        open_d = (cnt_d.count == LIMIT_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_q = cnt_q.count;
    assign open_q  = (cnt_q.count == LIMIT_C);

endmodule

// File: rtl/snl_reg_bank.sv
module snl_reg_bank #(
    parameter int                      BUS_W       = 4,
    parameter int                      NREG        = 1 << BUS_W,
    parameter logic [NREG-1:0]         STORED_MASK = '1,
    parameter logic [NREG*BUS_W-1:0]   RESET_IMAGE = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [BUS_W-1:0]      wr_addr,
    input  logic [BUS_W-1:0]      wr_data,
    input  logic                  open_d,
    output logic [NREG*BUS_W-1:0] image_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (STORED_MASK[i]) begin : g_live
            logic [BUS_W-1:0] prog_d, prog_q;
            logic [BUS_W-1:0] out_d, out_q;

            always_comb begin
                prog_d = prog_q;
                if (wr_en && (wr_addr == BUS_W'(i))) begin
                    prog_d = wr_data;
                end
                // Transparent once open: the slot shows its programming value.
                out_d = open_d ? prog_d : out_q;
            end

            // Programming slot is deliberately left without reset.
            always_ff @(posedge clk) begin
                prog_q <= prog_d;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= RESET_IMAGE[i*BUS_W +: BUS_W];
                end else begin
                    out_q <= out_d;
                end
            end

            assign image_o[i*BUS_W +: BUS_W] = out_q;
        end else begin : g_gap
            assign image_o[i*BUS_W +: BUS_W] = RESET_IMAGE[i*BUS_W +: BUS_W];
        end
    end

endmodule

// File: rtl/snl_loader.sv
module snl_loader #(
    parameter int                                 BUS_W         = 4,
    parameter int                                 SYNC_STAGES   = 2,
    parameter int                                 UNLOCK_WRITES = 32,
    parameter logic [(1<<BUS_W)-1:0]              STORED_MASK   = 16'h9FFF,
    parameter logic [(1<<BUS_W)*BUS_W-1:0]        RESET_IMAGE   = 64'h0000_0020_0000_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          strobe_i,
    input  logic [BUS_W-1:0]              bus_i,
    output logic [(1<<BUS_W)*BUS_W-1:0]   ctrl_o
);

    localparam int NREG  = 1 << BUS_W;
    localparam int CNT_W = $clog2(UNLOCK_WRITES + 1);

    logic             stb_s;
    logic [BUS_W-1:0] bus_s;
    logic             wr_en;
    logic [BUS_W-1:0] wr_addr;
    logic [BUS_W-1:0] wr_data;
    logic             stb_rise;
    logic             armed;
    logic [CNT_W-1:0] count_q;
    logic             open_d;
    logic             unlocked_q;

    // Strobe and bus share one chain so their sampled values stay aligned.
    snl_sync #(
        .W      (BUS_W + 1),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .d_i ({strobe_i, bus_i}),
        .q_o ({stb_s, bus_s})
    );

    snl_strobe_decoder #(
        .BUS_W (BUS_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_s    (stb_s),
        .bus_s    (bus_s),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stb_rise (stb_rise),
        .armed    (armed)
    );

    snl_unlock_counter #(
        .LIMIT (UNLOCK_WRITES),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .count_q (count_q),
        .open_d  (open_d),
        .open_q  (unlocked_q)
    );

    snl_reg_bank #(
        .BUS_W       (BUS_W),
        .NREG        (NREG),
        .STORED_MASK (STORED_MASK),
        .RESET_IMAGE (RESET_IMAGE)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .open_d  (open_d),
        .image_o (ctrl_o)
    );

endmodule

// File: rtl/snl_loader_chk.sv
module snl_loader_chk #(
    parameter int                        BUS_W       = 4,
    parameter int                        NREG        = 16,
    parameter int                        LIMIT       = 32,
    parameter int                        CNT_W       = 6,
    parameter logic [NREG-1:0]           STORED_MASK = '1,
    parameter logic [NREG*BUS_W-1:0]     RESET_IMAGE = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [BUS_W-1:0]      wr_addr,
    input logic [BUS_W-1:0]      wr_data,
    input logic                  stb_rise,
    input logic                  armed,
    input logic [CNT_W-1:0]      count_q,
    input logic                  unlocked_q,
    input logic [NREG*BUS_W-1:0] ctrl_o
);

    function automatic logic [BUS_W-1:0] nib(input logic [NREG*BUS_W-1:0] img,
                                             input logic [BUS_W-1:0] a);
        return img[a*BUS_W +: BUS_W];
    endfunction

    // R3: defaults are held until the unlock count is reached
    a_r3_locked_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked_q |-> ctrl_o == RESET_IMAGE);

    // R2: each completed write below the limit advances the count by one
    a_r2_write_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked_q) |=> count_q == CNT_W'($past(count_q) + 1'b1));

    // R4: once open, a stored write shows on the next edge
    a_r4_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked_q && wr_en && STORED_MASK[wr_addr])
        |=> nib(ctrl_o, $past(wr_addr)) == $past(wr_data));

    // R5: writes to the gap slots leave the image unchanged
    a_r5_gap_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !STORED_MASK[wr_addr]) |=> $stable(ctrl_o));

    // R7: an orphan rising edge does not count
    a_r7_orphan_uncounted: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && !armed) |=> $stable(count_q));

    // R8: count never passes the limit and unlock is sticky
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(LIMIT));

    a_r8_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked_q |=> unlocked_q);

endmodule

bind snl_loader snl_loader_chk #(
    .BUS_W       (BUS_W),
    .NREG        (NREG),
    .LIMIT       (UNLOCK_WRITES),
    .CNT_W       (CNT_W),
    .STORED_MASK (STORED_MASK),
    .RESET_IMAGE (RESET_IMAGE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .stb_rise   (stb_rise),
    .armed      (armed),
    .count_q    (count_q),
    .unlocked_q (unlocked_q),
    .ctrl_o     (ctrl_o)
);

// File: tb/sim_snl_loader.sv
module sim_snl_loader;

    localparam int          LIMIT = 32;
    localparam logic [15:0] MASK  = 16'h9FFF;
    localparam logic [63:0] DEF   = 64'h0000_0020_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b1;
    logic [3:0]  bus = 4'hF;
    logic [63:0] ctrl;

    always #4 clk = ~clk;

    snl_loader u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe),
        .bus_i    (bus),
        .ctrl_o   (ctrl)
    );

    int         checks = 0;
    int         errors = 0;
    int         wcount = 0;
    bit         done = 1'b0;
    logic [3:0] prog [16];

    function automatic logic [63:0] model_image();
        logic [63:0] img;
        img = DEF;
        if (wcount >= LIMIT) begin
            for (int i = 0; i < 16; i++) begin
                if (MASK[i]) img[i*4 +: 4] = prog[i];
            end
        end
        return img;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1/R2 handshake: address on falling strobe, data on rising strobe.
    task automatic do_write(input logic [3:0] a, input logic [3:0] d, input string req);
        @(negedge clk);
        bus = a;
        wait_cyc(3);
        strobe = 1'b0;
        wait_cyc(3);
        bus = d;
        wait_cyc(3);
        strobe = 1'b1;
        wait_cyc(4);
        bus = 4'($urandom % 16);
        if (MASK[a]) prog[a] = d;
        if (wcount < LIMIT) wcount++;
        check(req, ctrl, model_image());
    endtask

    task automatic do_reset(input bit hold_low);
        @(negedge clk);
        rst_n = 1'b0;
        strobe = hold_low ? 1'b0 : 1'b1;
        bus = 4'hF;
        wait_cyc(6);
        check("R9 reset image", ctrl, DEF);
        rst_n = 1'b1;
        wcount = 0;
        wait_cyc(3);
    endtask

    function automatic logic [3:0] fresh(input int slot);
        logic [3:0] v;
        v = 4'(($urandom % 15) + 1);
        if (v == DEF[slot*4 +: 4]) v = v + 4'd1;
        return v;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        void'($urandom(32'd1572));
        for (int i = 0; i < 16; i++) prog[i] = 4'h0;

        // R9 + R7: strobe held low through reset, then an orphan rise.
        do_reset(1'b1);
        @(negedge clk);
        bus = 4'h3;
        wait_cyc(3);
        strobe = 1'b1;
        wait_cyc(4);
        check("R7 orphan rise ignored", ctrl, DEF);

        // R3: program every stored slot while still locked.
        for (int a = 0; a < 16; a++) begin
            if (MASK[a] && a != 10) do_write(4'(a), fresh(a), "R3 locked");
        end
        // R5: dummy writes to the gap slots still count.
        while (wcount < LIMIT - 1) begin
            do_write((wcount % 2 == 0) ? 4'd13 : 4'd14, 4'(($urandom % 16)), "R5 dummy write counts");
        end
        check("R7 orphan not counted, still locked after 31", ctrl, DEF);
        // 32nd write unlocks; slot 10 must appear (R6).
        do_write(4'd10, 4'hA, "R3 unlock on 32nd write");
        check("R6 slot 10 stored", {60'd0, ctrl[43:40]}, {60'd0, 4'hA});

        // R4: random writes after unlock take effect immediately.
        for (int n = 0; n < 60; n++) begin
            do_write(4'($urandom % 16), 4'($urandom % 16), "R4 immediate write");
        end
        do_write(4'd13, 4'hF, "R5 gap write inert");
        do_write(4'd14, 4'h7, "R5 gap write inert");
        do_write(4'd9, 4'h5, "R2 data to slot 9");
        do_write(4'd8, 4'h6, "R1 address from falling edge");
        do_write(4'd15, 4'hC, "R1 address kept despite bus change");

        // R8: second reset relocks; saturation meant no wrap above.
        do_reset(1'b0);
        for (int n = 0; n < LIMIT - 1; n++) begin
            do_write(4'($urandom % 16), fresh(n % 16), "R8 relocked after reset");
        end
        do_write(4'd0, 4'h9, "R8 unlock again after 32");
        do_write(4'd1, 4'h4, "R8 stays unlocked");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule